// File: doc/BRIEF.md
# Strided Interleaved Vector Memory Unit

This unit moves one vector between an interleaved, banked word memory and a streaming interface. A command supplies a starting word address, a word stride, an element count and a direction. For every element the unit computes the word address as the starting address plus the element number times the stride, and it sends the access to the bank picked by that address.

Each bank needs a rest period after every access. The unit keeps a timer for each bank and holds the next element back while its bank is still resting. As a result, the stride sets the throughput: a stride that visits many banks streams at one element per cycle, and a stride that keeps returning to the same bank slows to the bank rest rate. Loads come back after a fixed latency, in element order, each tagged with its element number. Stores take one data word from the store stream per element. A one-cycle completion pulse ends every command.

The banks are held inside the unit as plain synchronous-read arrays.

Top module: `vec_mem_unit`

## Requirements
- R1: The word address of element i is (base + i*stride) mod 2^ADDR_W, with the default ADDR_W=8. The bank is the low 4 bits of that address and the row inside the bank is the upper 4 bits. A stride of 255 therefore walks the addresses downwards.
- R2: At most one element access is issued per cycle, in strictly increasing element order. Load results appear in element order, and ridx_o carries the element number.
- R3: After a bank is accessed, it takes no further access for 4 cycles. The unit stalls on such a conflict. A stride that is a multiple of 16 therefore delivers exactly one element every 4 cycles, and a stride of 8 delivers elements with gaps that alternate between 1 and 3 cycles.
- R4: Load data for an element is valid on the outputs 12 cycles after the cycle in which its access is issued. When all banks are idle, element 0 of a load is visible 13 cycles after the cycle in which start_i is accepted.
- R5: A store element is issued only in a cycle where wdata_valid_i is high. wdata_take_o is high in exactly those cycles, and the word on wdata_i in that cycle is written to the element's address.
- R6: busy_o is high from the cycle after a start is accepted until completion. done_o is a single-cycle pulse. It appears 2 cycles after the last load result, or 2 cycles after the last store issue, and busy_o falls in the same cycle.
- R7: A length of zero makes no access and produces no store take and no load result. done_o pulses 2 cycles after the start cycle.
- R8: start_i is ignored while busy_o is high. The running command continues unchanged.
- R9: After reset, busy_o, done_o, rdata_valid_o and wdata_take_o are low.
- R10: A unit-stride load with free banks delivers one element per cycle. A length above 64 is clamped to 64 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a command (accepted when not busy) |
| dir_store_i | input | 1 | 1 = store to memory, 0 = load from memory |
| base_i | input | ADDR_W | Starting word address |
| stride_i | input | ADDR_W | Word stride (modulo address space) |
| len_i | input | VL_W | Element count, clamped to MAX_VL |
| wdata_valid_i | input | 1 | Store stream word available |
| wdata_i | input | DATA_W | Store stream word |
| wdata_take_o | output | 1 | Store word consumed this cycle |
| rdata_valid_o | output | 1 | Load result valid |
| ridx_o | output | VL_W | Element number of the load result |
| rdata_o | output | DATA_W | Load result word |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command complete pulse |

## Verification
The assertions assume the following about the inputs:
- start_i is acted on only when busy_o is low, so the expected element number restarts only on an accepted start.
- The store stream holds its word steady until the clock edge in a cycle where wdata_take_o is high.

The stimulus changes inputs only just after a rising edge and raises start_i for a single cycle. On purpose, it also pulses start_i once during a running load, which checks that the command is ignored. The store stream is driven both continuously and with periodic gaps. Data is checked only on addresses that an earlier store in the same run has written.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  typedef enum logic {
    XFER_LOAD  = 1'b0,
    XFER_STORE = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/vmu_addr_gen.sv
module vmu_addr_gen #(
  parameter int ADDR_W = 8,
  parameter int VL_W   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_cmd,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic [VL_W-1:0]   elem
);
  logic [ADDR_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      elem   <= '0;
      step_q <= '0;
    end else if (load_cmd) begin
      addr   <= base;
      elem   <= '0;
      step_q <= stride;
    end else if (advance) begin
      addr <= addr + step_q;
      elem <= elem + 1'b1;
    end
  end
endmodule

// File: rtl/vmu_bank_timers.sv
module vmu_bank_timers #(
  parameter int NBANK    = 16,
  parameter int BUSY_CYC = 4,
  localparam int BANK_W  = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [BANK_W-1:0] hit_bank,
  output logic [NBANK-1:0]  resting
);
  localparam int TMR_W = $clog2(BUSY_CYC + 1);
  localparam logic [TMR_W-1:0] RELOAD = TMR_W'(BUSY_CYC - 1);

  for (genvar b = 0; b < NBANK; b++) begin : g_tmr
    logic [TMR_W-1:0] tmr_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        tmr_q <= '0;
      end else if (hit && (hit_bank == BANK_W'(b))) begin
        tmr_q <= RELOAD;
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
    assign resting[b] = (tmr_q != '0);
  end
endmodule

// File: rtl/vmu_bank_array.sv
module vmu_bank_array #(
  parameter int NBANK  = 16,
  parameter int ROW_W  = 4,
  parameter int DATA_W = 64,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] bank_q [NBANK];
  logic [BANK_W-1:0] sel_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DATA_W-1:0] cells [0:ROWS-1];
    logic              pick;
    assign pick = (bank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (wr_en && pick) cells[row] <= wr_data;
      if (rd_en && pick) bank_q[b] <= cells[row];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        sel_q <= '0;
    else if (rd_en) sel_q <= bank;
  end

  assign rd_data = bank_q[sel_q];
endmodule

// File: rtl/vmu_lat_pipe.sv
module vmu_lat_pipe #(
  parameter int STAGES = 11,
  parameter int VL_W   = 7,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [VL_W-1:0]   in_idx,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [VL_W-1:0]   out_idx,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_q  [STAGES];
  logic [VL_W-1:0]   idx_q  [STAGES];
  logic [DATA_W-1:0] data_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) vld_q[k] <= 1'b0;
    end else begin
      vld_q[0] <= in_vld;
      for (int k = 1; k < STAGES; k++) vld_q[k] <= vld_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    idx_q[0]  <= in_idx;
    data_q[0] <= in_data;
    for (int k = 1; k < STAGES; k++) begin
      idx_q[k]  <= idx_q[k-1];
      data_q[k] <= data_q[k-1];
    end
  end

  assign out_vld  = vld_q[STAGES-1];
  assign out_idx  = idx_q[STAGES-1];
  assign out_data = data_q[STAGES-1];
endmodule

// File: rtl/vec_mem_unit.sv
module vec_mem_unit #(
  parameter int NBANK    = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 64,
  parameter int MAX_VL   = 64,
  parameter int BUSY_CYC = 4,
  parameter int LAT_CYC  = 12,
  parameter int VL_W     = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dir_store_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VL_W-1:0]   len_i,
  input  logic              wdata_valid_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              wdata_take_o,
  output logic              rdata_valid_o,
  output logic [VL_W-1:0]   ridx_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o
);
  import vmu_pkg::*;

  localparam int BANK_W = $clog2(NBANK);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam logic [VL_W-1:0] MAX_LEN = VL_W'(MAX_VL);

  xfer_dir_e         dir_q;
  logic              active_q, done_q, is_store;
  logic [VL_W-1:0]   len_q, deliv_q, len_clamped, cnt;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] bank;
  logic [ROW_W-1:0]  row;
  logic [NBANK-1:0]  resting;
  logic              start_acc, all_issued, fire, finish;
  logic              ld_v0;
  logic [VL_W-1:0]   ld_idx0;
  logic [DATA_W-1:0] bank_rd;

  assign start_acc   = start_i & ~active_q;
  assign len_clamped = (len_i > MAX_LEN) ? MAX_LEN : len_i;
  assign is_store    = (dir_q == XFER_STORE);
  assign all_issued  = (cnt == len_q);
  assign bank        = addr[BANK_W-1:0];
  assign row         = addr[ADDR_W-1:BANK_W];
  assign fire        = active_q & ~all_issued & ~resting[bank] & (~is_store | wdata_valid_i);
  assign finish      = active_q & all_issued & (is_store | (deliv_q == len_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      dir_q    <= XFER_LOAD;
      len_q    <= '0;
      deliv_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (start_acc) begin
        active_q <= 1'b1;
        dir_q    <= xfer_dir_e'(dir_store_i);
        len_q    <= len_clamped;
        deliv_q  <= '0;
      end else begin
        if (finish) active_q <= 1'b0;
        if (rdata_valid_o) deliv_q <= deliv_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_v0   <= 1'b0;
      ld_idx0 <= '0;
    end else begin
      ld_v0   <= fire & ~is_store;
      ld_idx0 <= cnt;
    end
  end

  vmu_addr_gen #(.ADDR_W(ADDR_W), .VL_W(VL_W)) u_agen (
    .clk(clk), .rst(rst), .load_cmd(start_acc), .base(base_i), .stride(stride_i),
    .advance(fire), .addr(addr), .elem(cnt)
  );

  vmu_bank_timers #(.NBANK(NBANK), .BUSY_CYC(BUSY_CYC)) u_tmr (
    .clk(clk), .rst(rst), .hit(fire), .hit_bank(bank), .resting(resting)
  );

  vmu_bank_array #(.NBANK(NBANK), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst), .rd_en(fire & ~is_store), .wr_en(fire & is_store),
    .bank(bank), .row(row), .wr_data(wdata_i), .rd_data(bank_rd)
  );

  vmu_lat_pipe #(.STAGES(LAT_CYC - 1), .VL_W(VL_W), .DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst(rst), .in_vld(ld_v0), .in_idx(ld_idx0), .in_data(bank_rd),
    .out_vld(rdata_valid_o), .out_idx(ridx_o), .out_data(rdata_o)
  );

  assign wdata_take_o = fire & is_store;
  assign busy_o       = active_q;
  assign done_o       = done_q;
endmodule

// File: rtl/vmu_checker.sv
module vmu_checker #(
  parameter int NBANK    = 16,
  parameter int BUSY_CYC = 4,
  parameter int LAT_CYC  = 12,
  parameter int VL_W     = 7,
  localparam int BANK_W  = $clog2(NBANK)
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              wdata_valid_i,
  input logic              wdata_take_o,
  input logic              rdata_valid_o,
  input logic [VL_W-1:0]   ridx_o,
  input logic              done_o,
  input logic              fire,
  input logic [BANK_W-1:0] fire_bank,
  input logic              fire_store
);
  localparam int AGE_W = $clog2(BUSY_CYC + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(BUSY_CYC);

  logic [AGE_W-1:0]   age [NBANK];
  logic [LAT_CYC-1:0] lat_sr;
  logic [VL_W-1:0]    exp_idx;
  logic               bank_rested;

  for (genvar b = 0; b < NBANK; b++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst)                                     age[b] <= AGE_MAX;
      else if (fire && (fire_bank == BANK_W'(b)))  age[b] <= AGE_W'(1);
      else if (age[b] < AGE_MAX)                   age[b] <= age[b] + 1'b1;
    end
  end

  assign bank_rested = (age[fire_bank] >= AGE_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_sr  <= '0;
      exp_idx <= '0;
    end else begin
      lat_sr <= {lat_sr[LAT_CYC-2:0], fire & ~fire_store};
      if (start_i && !busy_o) exp_idx <= '0;
      else if (rdata_valid_o) exp_idx <= exp_idx + 1'b1;
    end
  end

  AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) wdata_take_o |-> wdata_valid_i); // R5
  AST_BANK_RESTED: assert property (@(posedge clk) disable iff (rst) fire |-> bank_rested); // R3
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (rst) rdata_valid_o == lat_sr[LAT_CYC-1]); // R4
  AST_IDX_IN_ORDER: assert property (@(posedge clk) disable iff (rst) rdata_valid_o |-> ridx_o == exp_idx); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R6
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst) !busy_o |-> !fire && !wdata_take_o); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) done_o |-> !busy_o); // R6
endmodule

bind vec_mem_unit vmu_checker #(
  .NBANK(NBANK), .BUSY_CYC(BUSY_CYC), .LAT_CYC(LAT_CYC), .VL_W(VL_W)
) u_vmu_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
  .wdata_valid_i(wdata_valid_i), .wdata_take_o(wdata_take_o),
  .rdata_valid_o(rdata_valid_o), .ridx_o(ridx_o), .done_o(done_o),
  .fire(fire), .fire_bank(bank), .fire_store(is_store)
);

// File: tb/vec_mem_unit_tb_top.sv
`timescale 1ns/1ps
module vec_mem_unit_tb_top;
  localparam int AW = 8;
  localparam int DW = 64;
  localparam int VW = 7;
  localparam int BUSY = 4;
  localparam int LAT = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, dir_store_i = 1'b0, wdata_valid_i = 1'b0;
  logic [AW-1:0] base_i = '0, stride_i = '0;
  logic [VW-1:0] len_i = '0;
  logic [DW-1:0] wdata_i;
  logic wdata_take_o, rdata_valid_o, busy_o, done_o;
  logic [VW-1:0] ridx_o;
  logic [DW-1:0] rdata_o;

  always #4 clk = ~clk;

  vec_mem_unit dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .dir_store_i(dir_store_i),
    .base_i(base_i), .stride_i(stride_i), .len_i(len_i),
    .wdata_valid_i(wdata_valid_i), .wdata_i(wdata_i), .wdata_take_o(wdata_take_o),
    .rdata_valid_o(rdata_valid_o), .ridx_o(ridx_o), .rdata_o(rdata_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference state
  bit m_act, m_store, m_done;
  int m_cnt, m_len, m_deliv, m_base, m_stride, cyc;
  int m_busy [16];
  logic [DW-1:0] mem [256];
  bit wr_ok [256];
  int qd[$], qi[$];
  logic [DW-1:0] qdat[$];
  bit qok[$];

  int wr_seq = 0, wv_mode = 0, wv_tick = 0, cmd_tag = 0;
  bit pend_inc = 1'b0;
  int start_cyc, first_out, last_out, gap_min, gap_max, n_out, n_take, done_cnt, done_cyc;

  assign wdata_i = {32'hC0DE_0000 + 32'(cmd_tag), 32'(wr_seq)};

  always @(posedge clk) begin
    #1;
    if (pend_inc) wr_seq++;
    wv_tick++;
    wdata_valid_i = (wv_mode == 0) ? 1'b1 : ((wv_tick % 3) != 0);
  end

  always @(negedge clk) begin
    if (rst) begin
      m_act = 0; m_store = 0; m_done = 0; m_cnt = 0; m_len = 0; m_deliv = 0;
      for (int b = 0; b < 16; b++) m_busy[b] = 0;
      cyc = 0; pend_inc = 0;
    end else begin
      bit ev, cond, iss, start_ok;
      int addr, bank;
      cyc++;
      ev = (qd.size() > 0) && (qd[0] == cyc);
      chk(rdata_valid_o == ev, "R4", "load valid timing", rdata_valid_o, ev);
      if (ev) begin
        chk(ridx_o == qi[0][VW-1:0], "R2", "element index", ridx_o, qi[0]);
        if (qok[0]) chk(rdata_o == qdat[0], "R1", "load data at strided address", rdata_o, qdat[0]);
        if (n_out == 0) first_out = cyc;
        else begin
          if (cyc - last_out < gap_min) gap_min = cyc - last_out;
          if (cyc - last_out > gap_max) gap_max = cyc - last_out;
        end
        last_out = cyc; n_out++;
        void'(qd.pop_front()); void'(qi.pop_front()); void'(qdat.pop_front()); void'(qok.pop_front());
      end
      chk(done_o == m_done, "R6", "done pulse", done_o, m_done);
      chk(busy_o == m_act, "R6", "busy flag", busy_o, m_act);
      if (done_o) begin done_cnt++; done_cyc = cyc; end

      cond = m_act && (m_cnt == m_len) && (m_store || (m_deliv == m_len));
      addr = (m_base + m_cnt * m_stride) & 255;
      bank = addr & 15;
      iss = m_act && (m_cnt < m_len) && (m_busy[bank] == 0) && (!m_store || wdata_valid_i);
      chk(wdata_take_o == (iss && m_store), "R5", "store take", wdata_take_o, iss && m_store);
      pend_inc = iss && m_store;
      for (int b = 0; b < 16; b++) if (m_busy[b] > 0) m_busy[b]--;
      if (iss) begin
        m_busy[bank] = BUSY - 1;
        if (m_store) begin
          mem[addr] = wdata_i; wr_ok[addr] = 1; n_take++;
        end else begin
          qd.push_back(cyc + LAT); qi.push_back(m_cnt);
          qdat.push_back(mem[addr]); qok.push_back(wr_ok[addr]);
        end
        m_cnt++;
      end
      start_ok = !m_act && start_i;
      if (start_ok) begin
        m_act = 1; m_store = dir_store_i; m_len = (len_i > 64) ? 64 : int'(len_i);
        m_base = base_i; m_stride = stride_i; m_cnt = 0; m_deliv = 0; start_cyc = cyc;
      end else begin
        if (cond) m_act = 0;
        if (ev) m_deliv++;
      end
      m_done = cond;
    end
  end

  task automatic launch(input int base, input int stride, input int len, input bit st, input int mode);
    int d0;
    repeat (4) @(posedge clk);
    #1;
    cmd_tag++; wv_mode = mode;
    n_out = 0; n_take = 0; gap_min = 1000000; gap_max = 0; first_out = -1;
    d0 = done_cnt;
    start_i = 1; dir_store_i = st; base_i = AW'(base); stride_i = AW'(stride); len_i = VW'(len);
    @(posedge clk); #1 start_i = 0;
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin wr_ok[a] = 0; mem[a] = '0; end
    done_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(busy_o == 0, "R9", "busy after reset", busy_o, 0);
    chk(done_o == 0, "R9", "done after reset", done_o, 0);
    chk(rdata_valid_o == 0, "R9", "valid after reset", rdata_valid_o, 0);
    chk(wdata_take_o == 0, "R9", "take after reset", wdata_take_o, 0);

    launch(0, 1, 64, 1, 0);                 // R5 unit-stride store
    chk(n_take == 64, "R5", "store takes", n_take, 64);
    launch(64, 3, 40, 1, 1);                // R5 store with gaps in the stream
    chk(n_take == 40, "R5", "gappy store takes", n_take, 40);

    launch(0, 1, 100, 0, 0);                // R10 clamp, unit stride rate, R4 latency
    chk(n_out == 64, "R10", "clamped length", n_out, 64);
    chk(gap_min == 1 && gap_max == 1, "R10", "unit stride gap", gap_max, 1);
    chk(first_out - start_cyc == 13, "R4", "first result delay", first_out - start_cyc, 13);
    chk(done_cyc - last_out == 2, "R6", "done after last result", done_cyc - last_out, 2);

    launch(5, 16, 10, 0, 0);                // R3 single-bank stride
    chk(n_out == 10, "R3", "stride16 count", n_out, 10);
    chk(gap_min == 4 && gap_max == 4, "R3", "stride16 spacing", gap_min, 4);

    launch(0, 8, 8, 0, 0);                  // R3 two-bank stride
    chk(gap_min == 1 && gap_max == 3, "R3", "stride8 spacing", gap_max, 3);

    launch(64, 3, 40, 0, 0);                // R1 data check on strided addresses
    chk(n_out == 40, "R1", "stride3 count", n_out, 40);
    launch(10, 255, 12, 0, 0);              // R1 downward wrap
    chk(n_out == 12, "R1", "negative stride count", n_out, 12);

    launch(0, 1, 0, 0, 0);                  // R7 zero length load
    chk(n_out == 0, "R7", "zero-length results", n_out, 0);
    chk(done_cyc - start_cyc == 2, "R7", "zero-length done delay", done_cyc - start_cyc, 2);
    launch(0, 1, 0, 1, 0);                  // R7 zero length store
    chk(n_take == 0, "R7", "zero-length takes", n_take, 0);

    // R8 start while busy is ignored
    begin
      int d0;
      repeat (4) @(posedge clk);
      #1;
      cmd_tag++; wv_mode = 0; n_out = 0; n_take = 0; d0 = done_cnt;
      start_i = 1; dir_store_i = 0; base_i = 8'd20; stride_i = 8'd1; len_i = 7'd20;
      @(posedge clk); #1 start_i = 0;
      repeat (5) @(posedge clk);
      #1 start_i = 1; dir_store_i = 1; len_i = 7'd3;
      @(posedge clk); #1 start_i = 0;
      while (done_cnt == d0) @(negedge clk);
      @(negedge clk);
      chk(n_out == 20, "R8", "results of running load", n_out, 20);
      chk(n_take == 0, "R8", "no store taken", n_take, 0);
    end
    repeat (4) @(negedge clk);
    chk(busy_o == 0, "R8", "idle after ignored start", busy_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R6 actual=%0h expected=%0h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule